// File: doc/BRIEF.md
# Selectable Meter Equation Datapath

This block forms per-element watt products from a stream of tagged voltage and current samples. Each sample arrives with a channel tag that names a current or voltage input. A 3-bit equation code chooses which product each element carries. The block keeps the earlier samples of a frame. When the last sample of the frame arrives, it registers up to two signed element products. It then pulses a valid strobe for one cycle, so that a downstream energy accumulator can add the results in.

The equation code has three valid settings:

- **Code 0:** both elements share voltage A. One element uses current A and the other uses current B.
- **Code 1:** a single element multiplies voltage A by half the difference of the two currents.
- **Code 2:** each element has its own voltage and current pair.

Any other code gives zero results and raises a flag that marks the mode as invalid.

Top module: `meter_eq_dp`

## Requirements
- R1: Channel tags are 0 for current A, 1 for voltage A, 2 for current B and 3 for voltage B. A sample is taken only in a cycle where `smp_valid` is high. Samples are 24-bit two's complement and element results are 48-bit two's complement.
- R2: With code 0 the frame order is current A, voltage A, current B, and the frame ends on the current B sample. Element 0 is voltage A times current A, and element 1 is voltage A times current B.
- R3: With code 1 the frame ends on the current B sample. Element 0 is voltage A times ((current A − current B) arithmetically shifted right by one), where the shift rounds toward minus infinity and happens before the multiply. Element 1 is zero.
- R4: With code 2 the frame order is current A, voltage A, current B, voltage B, and the frame ends on the voltage B sample. Element 0 is voltage A times current A, and element 1 is voltage B times current B.
- R5: Codes 3 to 7 end the frame on the current B sample and give zero in both elements. `bad_mode` is high whenever `eq_sel` holds 3 to 7, and low for codes 0 to 2.
- R6: `out_valid` is high for exactly one cycle: the cycle after the clock edge that accepts the frame's last sample. The new element values appear in that same cycle.
- R7: Outside a frame end, the element outputs keep their values. In any code other than 2, a voltage B sample neither pulses `out_valid` nor changes the outputs.
- R8: While `rst_n` is low, both element outputs are zero and `out_valid` is low.
- R9: The equation code used for a frame is the value on `eq_sel` in the cycle that takes the frame's last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eq_sel | input | 3 | Equation code |
| smp_valid | input | 1 | Sample present this cycle |
| smp_chan | input | 2 | Channel tag of the sample |
| smp_data | input | SW (24) | Signed sample value |
| el0 | output | 2*SW (48) | Element 0 product |
| el1 | output | 2*SW (48) | Element 1 product |
| out_valid | output | 1 | One-cycle strobe for fresh element values |
| bad_mode | output | 1 | Equation code is reserved |

## Verification
The hardest case to reach is the half-difference mode when the current difference is odd and negative, or when it lies at the edges of the 24-bit range. Only there do the rounding of the shift and the extra bit of the difference show in the product. The stimulus sweeps every equation code over a fixed set of values. The set includes both range extremes and small odd numbers, so each pairing of currents produces sign-mixed, odd and full-scale differences. Stray voltage B samples and an equation code that changes in mid-frame are driven as separate cases.

// File: rtl/meter_eq_dp.sv
module meter_eq_dp #(
  parameter int SW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           eq_sel,
  input  logic                 smp_valid,
  input  logic [1:0]           smp_chan,
  input  logic signed [SW-1:0] smp_data,
  output logic signed [2*SW-1:0] el0,
  output logic signed [2*SW-1:0] el1,
  output logic                 out_valid,
  output logic                 bad_mode
);
  localparam int PW = 2 * SW;

  logic signed [SW-1:0] ia_q, va_q, ib_q;
  logic signed [SW-1:0] ib_now;
  logic signed [SW:0]   diff, half;
  logic signed [PW-1:0] ia_x, va_x, ib_x, ibq_x, vb_x, half_x;
  logic signed [PW-1:0] n0, n1;
  logic                 frame_end;

  assign bad_mode  = eq_sel > 3'd2;
  assign frame_end = smp_valid && ((eq_sel == 3'd2) ? (smp_chan == 2'd3) : (smp_chan == 2'd2));
  assign ib_now    = (smp_valid && smp_chan == 2'd2) ? smp_data : ib_q;

  assign diff   = {ia_q[SW-1], ia_q} - {ib_now[SW-1], ib_now};
  assign half   = diff >>> 1;

  assign ia_x   = PW'(ia_q);
  assign va_x   = PW'(va_q);
  assign ib_x   = PW'(ib_now);
  assign ibq_x  = PW'(ib_q);
  assign vb_x   = PW'(smp_data);
  assign half_x = PW'(half);

  always_comb begin
    n0 = '0;
    n1 = '0;
    case (eq_sel)
      3'd0: begin n0 = va_x * ia_x;   n1 = va_x * ib_x;  end
      3'd1: begin n0 = va_x * half_x; n1 = '0;           end
      3'd2: begin n0 = va_x * ia_x;   n1 = vb_x * ibq_x; end
      default: begin n0 = '0; n1 = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ia_q <= '0;
      va_q <= '0;
      ib_q <= '0;
    end else if (smp_valid) begin
      case (smp_chan)
        2'd0: ia_q <= smp_data;
        2'd1: va_q <= smp_data;
        2'd2: ib_q <= smp_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      el0       <= '0;
      el1       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= frame_end;
      if (frame_end) begin
        el0 <= n0;
        el1 <= n1;
      end
    end
  end
endmodule

// File: rtl/meter_eq_dp_chk.sv
module meter_eq_dp_chk #(
  parameter int SW = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           eq_sel,
  input logic                 smp_valid,
  input logic [1:0]           smp_chan,
  input logic signed [2*SW-1:0] el0,
  input logic signed [2*SW-1:0] el1,
  input logic                 out_valid,
  input logic                 bad_mode
);
  logic last_in;
  assign last_in = smp_valid && (eq_sel == 3'd2 ? smp_chan == 2'd3 : smp_chan == 2'd2);

  p_strobe_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_in |=> out_valid);

  p_no_stray_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(last_in));

  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(el0) && $stable(el1)));

  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(eq_sel) > 3'd2) |-> (el0 == '0 && el1 == '0));

  p_half_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(eq_sel) == 3'd1) |-> el1 == '0);

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && el0 == '0 && el1 == '0));
endmodule

bind meter_eq_dp meter_eq_dp_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eq_sel(eq_sel), .smp_valid(smp_valid),
  .smp_chan(smp_chan), .el0(el0), .el1(el1), .out_valid(out_valid),
  .bad_mode(bad_mode)
);

// File: tb/tb_meter_eq_dp.sv
module tb_meter_eq_dp;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        eq_sel = 3'd0;
  logic              smp_valid = 1'b0;
  logic [1:0]        smp_chan = 2'd0;
  logic signed [23:0] smp_data = '0;
  logic signed [47:0] el0, el1;
  logic              out_valid, bad_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  meter_eq_dp dut (
    .clk(clk), .rst_n(rst_n), .eq_sel(eq_sel), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data), .el0(el0), .el1(el1),
    .out_valid(out_valid), .bad_mode(bad_mode)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int ch, input longint v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_chan  = 2'(ch);
    smp_data  = 24'(v);
  endtask

  task automatic frame(input int code, input longint ia, input longint va,
                       input longint ib, input longint vb, input bit stray_vb);
    longint e0, e1;
    eq_sel = 3'(code);
    put(0, ia);
    put(1, va);
    put(2, ib);
    if (code == 2) put(3, vb);
    case (code)
      0: begin e0 = va * ia; e1 = va * ib; end
      1: begin e0 = va * ((ia - ib) >>> 1); e1 = 0; end
      2: begin e0 = va * ia; e1 = vb * ib; end
      default: begin e0 = 0; e1 = 0; end
    endcase
    @(negedge clk);
    smp_valid = 1'b0;
    chk(out_valid == 1'b1, "R6 strobe after last sample", longint'(out_valid), 1);
    chk(longint'(el0) == e0, $sformatf("R2/R3/R4/R5 el0 code %0d", code), longint'(el0), e0);
    chk(longint'(el1) == e1, $sformatf("R2/R3/R4/R5 el1 code %0d", code), longint'(el1), e1);
    chk(bad_mode == (code > 2), "R5 bad_mode", longint'(bad_mode), longint'(code > 2));
    if (stray_vb && code != 2) begin
      put(3, 24'h123456);
      chk(out_valid == 1'b0, "R6 single-cycle strobe", longint'(out_valid), 0);
      @(negedge clk);
      smp_valid = 1'b0;
      chk(out_valid == 1'b0, "R7 voltage B ignored", longint'(out_valid), 0);
      chk(longint'(el0) == e0 && longint'(el1) == e1, "R7 outputs held",
          longint'(el0), e0);
    end else begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6 single-cycle strobe", longint'(out_valid), 0);
      chk(longint'(el0) == e0, "R7 outputs held", longint'(el0), e0);
    end
  endtask

  initial begin
    longint vals[8] = '{0, 1, -1, 8388607, -8388608, 12345, -777, 3};
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset strobe", longint'(out_valid), 0);
    chk(el0 == '0 && el1 == '0, "R8 reset outputs", longint'(el0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R3 R4 R5: sweep over all codes and value pairings
    for (int code = 0; code < 8; code++)
      for (int p = 0; p < 8; p++)
        frame(code, vals[p], vals[(p + 3) % 8], vals[(p + 5) % 8], vals[(p + 6) % 8], p[0]);
    // R3 odd negative and extreme differences
    frame(1, -8388608, 8388607, 8388607, 0, 1'b0);
    frame(1, 8388607, -8388608, -8388608, 0, 1'b0);
    frame(1, -4, 1000, 1, 0, 1'b0);
    // R1 samples without smp_valid are not taken
    eq_sel = 3'd0;
    put(0, 5); put(1, 7);
    @(negedge clk); smp_valid = 1'b0; smp_chan = 2'd0; smp_data = 24'(99);
    @(negedge clk); smp_chan = 2'd2;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 invalid cycle ignored", longint'(out_valid), 0);
    put(2, 11);
    @(negedge clk); smp_valid = 1'b0;
    chk(longint'(el0) == 35 && longint'(el1) == 77, "R1 capture on valid only",
        longint'(el0), 35);
    // R9 code taken at the last sample
    eq_sel = 3'd2;
    put(0, 6); put(1, 4);
    eq_sel = 3'd0;
    put(2, -3);
    @(negedge clk); smp_valid = 1'b0;
    chk(out_valid == 1'b1 && longint'(el1) == -12, "R9 code at last sample",
        longint'(el1), -12);
    // R8 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(el0 == '0 && el1 == '0 && !out_valid, "R8 reset clears", longint'(el0), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule